// File: doc/BRIEF.md
# In-Band Xon/Xoff Flow Controller

This block is the software flow-control logic of one serial channel. It sits between the receiver, the receive FIFO level and the transmitter. It compares every received character with two programmed flow characters, one meaning "stop" and one meaning "go". When receive-side gating is on, it uses them to hold or release the local transmitter. It also decides whether a received character is written into the receive FIFO.

When fill-level signalling is on, the block watches the receive FIFO level. It asks the transmitter to send the stop character when the FIFO runs high, and the go character once it has drained. It remembers whether a stop character is still unanswered. A request that is no longer wanted is withdrawn if the transmitter has not loaded it yet. Once the transmitter acknowledges a request, the character belongs to the shift register and the request is gone.

With both automatic functions off, host commands drive everything. The host can hold or resume the transmitter and queue either flow character, and a kill command cancels the queued one. In every mode the comparators raise a maskable recognition interrupt and record which flow character was seen last.

The shift registers and FIFO memories lie outside the block. The transmitter loads a queued FIFO character only while `tx_gate` is high. It loads an injected flow character whenever `inj_req` is high and the shift register is free, signalling the load with `inj_ack`.

Top module: `xflow_ctrl`

## Requirements
- R1: After reset `tx_gate` is 1 and `inj_req`, `irq` and `stat_xoff_out` are 0.
- R2: With `cfg_auto_tx` = 1, an accepted received character equal to `cfg_xoff_char` drives `tx_gate` to 0 from the next cycle. An accepted character equal to `cfg_xon_char` drives it back to 1 from the next cycle.
- R3: A received character that arrives while `rx_fifo_full` = 1 is not pushed. It changes neither `tx_gate` nor the interrupt state.
- R4: With room in the FIFO, `rx_push` follows `rx_valid` in the same cycle and carries the data and error bits unchanged. The exception is a flow character while `cfg_transparent` = 1, which is recognized but not pushed.
- R5: Error bits on a received flow character do not prevent it from being recognized.
- R6: With `cfg_auto_rx` = 1, `inj_req` is 1 in the same cycle under two conditions. It carries `cfg_xoff_char` when `rx_level` > 12 and no stop is outstanding. It carries `cfg_xon_char` when `rx_level` < 8 and a stop is outstanding.
- R7: If the level condition behind an automatic request clears before `inj_ack`, the request drops in that same cycle.
- R8: An acknowledged automatic stop character sets `stat_xoff_out` on the next cycle. An acknowledged go character clears it.
- R9: In host mode (both automatic bits 0), command 3 (hold) drops `tx_gate` from the next cycle. Command 4 (resume) raises it again. A received go character does not raise it.
- R10: In host mode, command 1 queues the go character and command 2 queues the stop character, each visible on `inj_req`/`inj_char` the next cycle. A later send command replaces the earlier one. Command 5 (kill) or `inj_ack` clears the queued character. Commands 1 to 5 are ignored while either automatic bit is 1.
- R11: Recognition of either flow character works in every mode and sets a pending flag. `stat_last_xoff` becomes 1 for a stop character and 0 for a go character. `irq` is the pending flag gated by `cfg_irq_en`. Command 6 clears the flag.
- R12: Clearing `cfg_auto_rx` clears `stat_xoff_out` without requesting a go character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_auto_tx | input | 1 | Received flow characters gate the transmitter |
| cfg_auto_rx | input | 1 | FIFO level triggers flow character sending |
| cfg_transparent | input | 1 | Recognized flow characters are not stored |
| cfg_irq_en | input | 1 | Recognition interrupt enable |
| cfg_xon_char | input | 8 | Go character |
| cfg_xoff_char | input | 8 | Stop character |
| rx_valid | input | 1 | Receiver delivers a character this cycle |
| rx_data | input | 8 | Received character |
| rx_err | input | 3 | Receive error bits of the character |
| rx_fifo_full | input | 1 | Receive FIFO has no room |
| rx_level | input | 5 | Receive FIFO fill level |
| rx_push | output | 1 | Write strobe into the receive FIFO |
| rx_push_data | output | 8 | Data written into the receive FIFO |
| rx_push_err | output | 3 | Error bits written into the receive FIFO |
| cmd_valid | input | 1 | Host command strobe |
| cmd_code | input | 3 | Host command code (1 send go, 2 send stop, 3 hold, 4 resume, 5 kill, 6 clear interrupt) |
| tx_gate | output | 1 | Transmitter may load its next FIFO character |
| inj_req | output | 1 | Flow character waiting to be sent |
| inj_char | output | 8 | Flow character to send |
| inj_ack | input | 1 | Transmitter loads the injected character |
| irq | output | 1 | Recognition interrupt |
| stat_last_xoff | output | 1 | Last recognized flow character was the stop character |
| stat_xoff_out | output | 1 | A sent stop character is not yet rescinded |

## Verification
The fill-level function is driven through a table of levels in a fixed order: below the low mark, exactly on 8 and 12, just above 12, and well above 12. Some rows acknowledge and some do not. This separates a request that is withdrawn from one that is consumed, and it tells the strict comparisons apart from inclusive ones at both marks. Receive-side patterns cover the stop and go characters with and without error bits. They also cover a non-flow character, arrival into a full FIFO, and transparency on and off, so that recognition, storage and gating can be told apart. Host command sequences check that a later send command replaces an earlier one, that kill cancels it, and that commands and received characters are ignored in the modes where they must have no effect.

// File: rtl/xflow_pkg.sv
package xflow_pkg;

  typedef enum logic [2:0] {
    XC_NOP       = 3'd0,
    XC_SEND_XON  = 3'd1,
    XC_SEND_XOFF = 3'd2,
    XC_HOLD      = 3'd3,
    XC_RESUME    = 3'd4,
    XC_KILL      = 3'd5,
    XC_CLR_IRQ   = 3'd6
  } xcmd_e;

  typedef enum logic [1:0] {
    HP_NONE = 2'd0,
    HP_XON  = 2'd1,
    HP_XOFF = 2'd2
  } hpend_e;

endpackage

// File: rtl/xflow_match.sv
module xflow_match #(
  parameter int DATA_W = 8,
  parameter int ERR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [ERR_W-1:0]  rx_err,
  input  logic              rx_fifo_full,
  input  logic              cfg_transparent,
  input  logic [DATA_W-1:0] xon_char,
  input  logic [DATA_W-1:0] xoff_char,
  input  logic              clr_irq,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_push_data,
  output logic [ERR_W-1:0]  rx_push_err,
  output logic              hit_xon,
  output logic              hit_xoff,
  output logic              irq_pend,
  output logic              last_xoff
);

  logic accept;
  logic is_xon, is_xoff;
  logic pend_q, pend_d;
  logic kind_q, kind_d;
  logic kind_en;

  // Comparators look at data only; error bits never veto recognition.
  assign accept   = rx_valid && !rx_fifo_full;
  assign is_xon   = (rx_data == xon_char);
  assign is_xoff  = (rx_data == xoff_char);
  assign hit_xon  = accept && is_xon;
  assign hit_xoff = accept && is_xoff;

  assign rx_push      = accept && !(cfg_transparent && (is_xon || is_xoff));
  assign rx_push_data = rx_data;
  assign rx_push_err  = rx_err;

  always_comb begin
    pend_d  = pend_q;
    kind_en = hit_xon || hit_xoff;
    kind_d  = hit_xoff;
    if (hit_xon || hit_xoff) pend_d = 1'b1;
    else if (clr_irq)        pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      kind_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (kind_en) kind_q <= kind_d;
    end
  end

  assign irq_pend  = pend_q;
  assign last_xoff = kind_q;

  p_overrun_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_fifo_full && !clr_irq) |=> (irq_pend == $past(irq_pend)));

  p_transparent_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_transparent && (hit_xon || hit_xoff)) |-> !rx_push);

  p_recog_sets_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_xon || hit_xoff) |=> irq_pend);

endmodule

// File: rtl/xflow_gate.sv
module xflow_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_tx,
  input  logic hit_xon,
  input  logic hit_xoff,
  input  logic cmd_hold,
  input  logic cmd_resume,
  output logic tx_gate
);

  logic hold_q, hold_d;

  always_comb begin
    hold_d = hold_q;
    if (auto_tx) begin
      if (hit_xoff)     hold_d = 1'b1;
      else if (hit_xon) hold_d = 1'b0;
    end else begin
      if (cmd_hold)        hold_d = 1'b1;
      else if (cmd_resume) hold_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  assign tx_gate = !hold_q;

  p_xoff_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_tx && hit_xoff) |=> !tx_gate);

  p_xon_frees_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_tx && hit_xon && !hit_xoff) |=> tx_gate);

  p_host_hold_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_tx && !tx_gate && !cmd_resume) |=> !tx_gate);

endmodule

// File: rtl/xflow_inject.sv
module xflow_inject
  import xflow_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int LVL_W   = 5,
  parameter int HI_MARK = 12,
  parameter int LO_MARK = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_rx,
  input  logic              host_mode,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [DATA_W-1:0] xon_char,
  input  logic [DATA_W-1:0] xoff_char,
  input  logic              cmd_send_xon,
  input  logic              cmd_send_xoff,
  input  logic              cmd_kill,
  input  logic              inj_ack,
  output logic              inj_req,
  output logic [DATA_W-1:0] inj_char,
  output logic              xoff_out
);

  localparam logic [LVL_W-1:0] HI_L = LVL_W'(HI_MARK);
  localparam logic [LVL_W-1:0] LO_L = LVL_W'(LO_MARK);

  logic   out_q, out_d;
  hpend_e pend_q, pend_d;
  logic   auto_xoff, auto_xon, host_req, pick_xoff, loaded;

  // Level-driven requests are combinational so a vanished condition withdraws them.
  assign auto_xoff = auto_rx && !out_q && (rx_level > HI_L);
  assign auto_xon  = auto_rx &&  out_q && (rx_level < LO_L);
  assign host_req  = (pend_q != HP_NONE);

  assign inj_req   = auto_rx ? (auto_xoff || auto_xon) : host_req;
  assign pick_xoff = auto_rx ? auto_xoff : (pend_q == HP_XOFF);
  assign inj_char  = pick_xoff ? xoff_char : xon_char;
  assign loaded    = inj_req && inj_ack;

  always_comb begin
    out_d = out_q;
    if (!auto_rx)                 out_d = 1'b0;
    else if (loaded && auto_xoff) out_d = 1'b1;
    else if (loaded && auto_xon)  out_d = 1'b0;
  end

  always_comb begin
    pend_d = pend_q;
    if (!host_mode)         pend_d = HP_NONE;
    else if (cmd_send_xon)  pend_d = HP_XON;
    else if (cmd_send_xoff) pend_d = HP_XOFF;
    else if (cmd_kill)      pend_d = HP_NONE;
    else if (loaded)        pend_d = HP_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= 1'b0;
      pend_q <= HP_NONE;
    end else begin
      out_q  <= out_d;
      pend_q <= pend_d;
    end
  end

  assign xoff_out = out_q;

  p_xoff_ack_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_xoff && inj_ack) |=> xoff_out);

  p_xon_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_xon && inj_ack) |=> !xoff_out);

  p_auto_off_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_rx |=> !xoff_out || auto_rx);

  p_kill_cancels_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_mode && cmd_kill && !auto_rx) |=> !(auto_rx) |-> !inj_req);

endmodule

// File: rtl/xflow_ctrl.sv
module xflow_ctrl
  import xflow_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ERR_W   = 3,
  parameter int LVL_W   = 5,
  parameter int HI_MARK = 12,
  parameter int LO_MARK = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_auto_tx,
  input  logic              cfg_auto_rx,
  input  logic              cfg_transparent,
  input  logic              cfg_irq_en,
  input  logic [DATA_W-1:0] cfg_xon_char,
  input  logic [DATA_W-1:0] cfg_xoff_char,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [ERR_W-1:0]  rx_err,
  input  logic              rx_fifo_full,
  input  logic [LVL_W-1:0]  rx_level,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_push_data,
  output logic [ERR_W-1:0]  rx_push_err,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_code,
  output logic              tx_gate,
  output logic              inj_req,
  output logic [DATA_W-1:0] inj_char,
  input  logic              inj_ack,
  output logic              irq,
  output logic              stat_last_xoff,
  output logic              stat_xoff_out
);

  xcmd_e cmd;
  logic  host_mode;
  logic  c_send_xon, c_send_xoff, c_hold, c_resume, c_kill, c_clr;
  logic  hit_xon, hit_xoff, irq_pend;

  assign cmd       = xcmd_e'(cmd_code);
  assign host_mode = !cfg_auto_tx && !cfg_auto_rx;

  // Flow commands act only in host mode; clearing the interrupt works always.
  assign c_send_xon  = cmd_valid && host_mode && (cmd == XC_SEND_XON);
  assign c_send_xoff = cmd_valid && host_mode && (cmd == XC_SEND_XOFF);
  assign c_hold      = cmd_valid && host_mode && (cmd == XC_HOLD);
  assign c_resume    = cmd_valid && host_mode && (cmd == XC_RESUME);
  assign c_kill      = cmd_valid && host_mode && (cmd == XC_KILL);
  assign c_clr       = cmd_valid && (cmd == XC_CLR_IRQ);

  xflow_match #(.DATA_W(DATA_W), .ERR_W(ERR_W)) u_match (
    .clk             (clk),
    .rst_n           (rst_n),
    .rx_valid        (rx_valid),
    .rx_data         (rx_data),
    .rx_err          (rx_err),
    .rx_fifo_full    (rx_fifo_full),
    .cfg_transparent (cfg_transparent),
    .xon_char        (cfg_xon_char),
    .xoff_char       (cfg_xoff_char),
    .clr_irq         (c_clr),
    .rx_push         (rx_push),
    .rx_push_data    (rx_push_data),
    .rx_push_err     (rx_push_err),
    .hit_xon         (hit_xon),
    .hit_xoff        (hit_xoff),
    .irq_pend        (irq_pend),
    .last_xoff       (stat_last_xoff)
  );

  xflow_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .auto_tx    (cfg_auto_tx),
    .hit_xon    (hit_xon),
    .hit_xoff   (hit_xoff),
    .cmd_hold   (c_hold),
    .cmd_resume (c_resume),
    .tx_gate    (tx_gate)
  );

  xflow_inject #(
    .DATA_W  (DATA_W),
    .LVL_W   (LVL_W),
    .HI_MARK (HI_MARK),
    .LO_MARK (LO_MARK)
  ) u_inject (
    .clk           (clk),
    .rst_n         (rst_n),
    .auto_rx       (cfg_auto_rx),
    .host_mode     (host_mode),
    .rx_level      (rx_level),
    .xon_char      (cfg_xon_char),
    .xoff_char     (cfg_xoff_char),
    .cmd_send_xon  (c_send_xon),
    .cmd_send_xoff (c_send_xoff),
    .cmd_kill      (c_kill),
    .inj_ack       (inj_ack),
    .inj_req       (inj_req),
    .inj_char      (inj_char),
    .xoff_out      (stat_xoff_out)
  );

  assign irq = irq_pend && cfg_irq_en;

  p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_irq_en |-> !irq);

  p_full_no_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_fifo_full) |=> (tx_gate == $past(tx_gate)));

endmodule

// File: tb/sim_xflow_ctrl.sv
module sim_xflow_ctrl;

  localparam logic [7:0] XON  = 8'h11;
  localparam logic [7:0] XOFF = 8'h13;

  logic       clk, rst_n;
  logic       cfg_auto_tx, cfg_auto_rx, cfg_transparent, cfg_irq_en;
  logic       rx_valid, rx_fifo_full, cmd_valid, inj_ack;
  logic [7:0] rx_data;
  logic [2:0] rx_err, cmd_code;
  logic [4:0] rx_level;
  logic       rx_push, tx_gate, inj_req, irq, stat_last_xoff, stat_xoff_out;
  logic [7:0] rx_push_data, inj_char;
  logic [2:0] rx_push_err;

  int n_chk, n_fail;
  bit done;

  xflow_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_auto_tx(cfg_auto_tx), .cfg_auto_rx(cfg_auto_rx),
    .cfg_transparent(cfg_transparent), .cfg_irq_en(cfg_irq_en),
    .cfg_xon_char(XON), .cfg_xoff_char(XOFF),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err),
    .rx_fifo_full(rx_fifo_full), .rx_level(rx_level),
    .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_push_err(rx_push_err),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .tx_gate(tx_gate), .inj_req(inj_req), .inj_char(inj_char), .inj_ack(inj_ack),
    .irq(irq), .stat_last_xoff(stat_last_xoff), .stat_xoff_out(stat_xoff_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {level, ack, expected req, expected char is stop, expected outstanding}
  localparam int NV = 13;
  localparam logic [8:0] VEC [NV] = '{
    {5'd5,  1'b0, 1'b0, 1'b0, 1'b0},
    {5'd12, 1'b0, 1'b0, 1'b0, 1'b0},
    {5'd13, 1'b0, 1'b1, 1'b1, 1'b0},
    {5'd12, 1'b0, 1'b0, 1'b0, 1'b0},
    {5'd20, 1'b1, 1'b1, 1'b1, 1'b0},
    {5'd20, 1'b0, 1'b0, 1'b0, 1'b1},
    {5'd8,  1'b0, 1'b0, 1'b0, 1'b1},
    {5'd7,  1'b0, 1'b1, 1'b0, 1'b1},
    {5'd9,  1'b0, 1'b0, 1'b0, 1'b1},
    {5'd0,  1'b1, 1'b1, 1'b0, 1'b1},
    {5'd0,  1'b0, 1'b0, 1'b0, 1'b0},
    {5'd13, 1'b0, 1'b1, 1'b1, 1'b0},
    {5'd13, 1'b1, 1'b1, 1'b1, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic ceq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic rx_char(input logic [7:0] d, input logic [2:0] e,
                         output logic pushed, output logic [2:0] perr);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_err = e;
    #1 pushed = rx_push; perr = rx_push_err;
    @(negedge clk);
    rx_valid = 1'b0;
    #1;
  endtask

  task automatic cmd(input logic [2:0] c);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = c;
    @(negedge clk);
    cmd_valid = 1'b0;
    #1;
  endtask

  initial begin
    logic p;
    logic [2:0] pe;
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 1'b0;
    cfg_auto_tx = 0; cfg_auto_rx = 0; cfg_transparent = 0; cfg_irq_en = 1;
    rx_valid = 0; rx_data = 0; rx_err = 0; rx_fifo_full = 0; rx_level = 0;
    cmd_valid = 0; cmd_code = 0; inj_ack = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    ceq("R1 gate", tx_gate, 1);
    ceq("R1 req", inj_req, 0);
    ceq("R1 irq", irq, 0);
    ceq("R1 out", stat_xoff_out, 0);

    // R6 R7 R8: fill-level table
    cfg_auto_rx = 1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      rx_level = VEC[i][8:4];
      inj_ack  = VEC[i][3];
      #1;
      ceq($sformatf("R6/R7 row %0d req", i), inj_req, VEC[i][2]);
      if (VEC[i][2])
        ceq($sformatf("R6 row %0d char", i), inj_char, VEC[i][1] ? XOFF : XON);
      ceq($sformatf("R8 row %0d out", i), stat_xoff_out, VEC[i][0]);
    end
    @(negedge clk) inj_ack = 0;
    #1 ceq("R8 out after ack", stat_xoff_out, 1);

    // R12
    @(negedge clk) begin cfg_auto_rx = 0; rx_level = 0; end
    @(negedge clk);
    #1;
    ceq("R12 out cleared", stat_xoff_out, 0);
    ceq("R12 no xon req", inj_req, 0);

    // R2 R4 R11
    cfg_auto_tx = 1;
    rx_char(XOFF, 3'd0, p, pe);
    ceq("R4 stop stored", p, 1);
    ceq("R2 gate held", tx_gate, 0);
    ceq("R11 irq", irq, 1);
    ceq("R11 last stop", stat_last_xoff, 1);
    rx_char(XON, 3'd0, p, pe);
    ceq("R2 gate freed", tx_gate, 1);
    ceq("R11 last go", stat_last_xoff, 0);

    // R5
    rx_char(XOFF, 3'b101, p, pe);
    ceq("R5 errored stop gates", tx_gate, 0);
    ceq("R4 err bits kept", pe, 3'b101);

    // R3
    cmd(3'd6);
    ceq("R11 clear", irq, 0);
    rx_fifo_full = 1;
    rx_char(XON, 3'd0, p, pe);
    ceq("R3 no push", p, 0);
    ceq("R3 gate unchanged", tx_gate, 0);
    ceq("R3 no irq", irq, 0);
    rx_fifo_full = 0;
    rx_char(XON, 3'd0, p, pe);
    ceq("R2 gate freed 2", tx_gate, 1);

    // R4 transparency
    cfg_transparent = 1;
    rx_char(XOFF, 3'd0, p, pe);
    ceq("R4 transparent stop dropped", p, 0);
    ceq("R4 transparent still gates", tx_gate, 0);
    rx_char(8'h41, 3'd0, p, pe);
    ceq("R4 plain char stored", p, 1);
    rx_char(XON, 3'd0, p, pe);
    ceq("R4 transparent go dropped", p, 0);
    ceq("R2 gate freed 3", tx_gate, 1);
    cfg_transparent = 0;

    // R10 ignored in auto mode
    cmd(3'd1);
    ceq("R10 send ignored in auto", inj_req, 0);
    cmd(3'd3);
    ceq("R10 hold ignored in auto", tx_gate, 1);

    // R9 host hold
    cfg_auto_tx = 0;
    cmd(3'd3);
    ceq("R9 hold", tx_gate, 0);
    rx_char(XON, 3'd0, p, pe);
    ceq("R9 go char ignored", tx_gate, 0);
    cmd(3'd4);
    ceq("R9 resume", tx_gate, 1);

    // R10 host send
    cmd(3'd2);
    ceq("R10 stop queued", inj_req, 1);
    ceq("R10 stop char", inj_char, XOFF);
    cmd(3'd1);
    ceq("R10 replaced req", inj_req, 1);
    ceq("R10 replaced char", inj_char, XON);
    cmd(3'd5);
    ceq("R10 kill", inj_req, 0);
    cmd(3'd2);
    @(negedge clk) inj_ack = 1;
    @(negedge clk) inj_ack = 0;
    #1 ceq("R10 ack clears", inj_req, 0);

    // R11 masking
    cmd(3'd6);
    cfg_irq_en = 0;
    rx_char(XOFF, 3'd0, p, pe);
    ceq("R11 masked", irq, 0);
    cfg_irq_en = 1;
    #1 ceq("R11 unmasked", irq, 1);
    ceq("R11 host-mode stop seen", stat_last_xoff, 1);
    cmd(3'd6);
    ceq("R11 cleared", irq, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule